// File: doc/BRIEF.md
# Finite-Precision Complex Multiplier

This block multiplies two complex numbers held as signed fixed-point fractions. It is meant for bit-true datapaths such as FFT twiddle rotation or an adaptive equalizer tap, where the hardware must match a software model bit for bit. Each of the four real cross products is cut back to the input width on its own. The four cut values are then combined into a real part (a difference) and an imaginary part (a sum). The combining adder keeps its carry, so the combination is exact.

One control bit picks how every product is cut: truncation (round toward minus infinity) or rounding (add one half LSB, then truncate). The control is sampled together with the operands, so each operand set carries its own mode. Results appear a fixed two cycles after the operands, marked by an output valid strobe. Between results the outputs hold their last values.

Top module: `cmul_fp`

## Requirements
- R1: `valid_out` is high in exactly the cycle two clock edges after `valid_in` was sampled high, and low otherwise; back-to-back inputs give back-to-back results.
- R2: While `rst_n` is low and after its release, until the first result arrives, `valid_out`, `re_out` and `im_out` are all zero.
- R3: `re_out` is the exact 9-bit two's-complement difference Q(a_re·b_re) − Q(a_im·b_im), where Q is the 8-bit product reduction. `re_out` never takes the value 9'h100.
- R4: `im_out` is the exact 9-bit two's-complement sum Q(a_re·b_im) + Q(a_im·b_re). `im_out` never exceeds +254 (9'h0FE).
- R5: With `rnd_mode` = 0 (truncate), Q(x·y) = floor(x·y / 128) on the raw signed integers. For example, 1·64 gives 0 and −1·64 gives −1.
- R6: With `rnd_mode` = 1 (round), Q(x·y) = floor((x·y + 64) / 128). For example, 1·64 gives 1 and −1·64 gives 0.
- R7: The product of −128 and −128 saturates to +127 in both modes. With all four inputs at −128, the result is `re_out` = 0 and `im_out` = +254.
- R8: `rnd_mode` is sampled with each operand set, so consecutive operand sets with different modes are each reduced in their own mode.
- R9: In any cycle where `valid_out` is low, `re_out` and `im_out` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands and mode are valid this cycle |
| rnd_mode | input | 1 | 0 = truncate, 1 = round, for all four reductions |
| a_re | input | 8 | Real part of operand A, signed fraction Q1.7 |
| a_im | input | 8 | Imaginary part of operand A, signed Q1.7 |
| b_re | input | 8 | Real part of operand B, signed Q1.7 |
| b_im | input | 8 | Imaginary part of operand B, signed Q1.7 |
| valid_out | output | 1 | Result valid, two cycles after `valid_in` |
| re_out | output | 9 | Real result, signed Q2.7 |
| im_out | output | 9 | Imaginary result, signed Q2.7 |

## Verification
Small products whose low seven bits are exactly zero, exactly half, or just above or below half separate truncation from rounding, and show where floor and round-half-up differ on negative values. The all −128 operand set isolates the saturating corner, which a wrapping cut would turn into −128. Back-to-back operand sets with alternating modes tell a mode sampled per item apart from one latched late. A long stream of random operands in both modes, with idle gaps, tests the full combination range against a reference model, the hold behaviour between results, and the valid timing.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  // Reduction mode applied to every partial product cut
  typedef enum logic {
    CUT_TRUNC = 1'b0,
    CUT_ROUND = 1'b1
  } cut_mode_e;

  localparam int unsigned CMUL_DATA_W = 8;
  localparam int unsigned CMUL_NPROD  = 4;
endpackage

// File: rtl/cmul_prod_reduce.sv
// One real multiplier followed by the cut back to input width.
// The product of two Q1.7 values is Q2.14. The redundant sign bit is dropped,
// an optional half LSB is added, and the result is saturated at the positive rail.
module cmul_prod_reduce #(
  parameter int unsigned W = 8
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  input  logic                round_en,
  output logic signed [W-1:0] q,
  output logic                sat
);
  localparam int unsigned PW   = 2 * W;
  localparam int unsigned FB   = W - 1;
  localparam int unsigned SW   = PW + 1 - FB;
  localparam logic [PW:0] HALF = (PW+1)'(1) << (FB - 1);
  localparam logic signed [SW-1:0] QMAX = SW'((1 << (W - 1)) - 1);

  logic signed [PW-1:0] prod;
  logic        [PW:0]   biased;
  logic signed [SW-1:0] shifted;

  always_comb begin
    prod    = PW'(x) * PW'(y);
    biased  = {prod[PW-1], prod} + (round_en ? HALF : '0);
    shifted = $signed(biased[PW:FB]);
    sat     = (shifted > QMAX);
    q       = sat ? QMAX[W-1:0] : shifted[W-1:0];
  end
endmodule

// File: rtl/cmul_combine.sv
// Second pipeline stage: exact difference and sum with one growth bit.
module cmul_combine #(
  parameter int unsigned W = 8,
  localparam int unsigned OW = W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [W-1:0]  p_rr,
  input  logic signed [W-1:0]  p_ii,
  input  logic signed [W-1:0]  p_ri,
  input  logic signed [W-1:0]  p_ir,
  output logic                 valid_q,
  output logic signed [OW-1:0] re_q,
  output logic signed [OW-1:0] im_q
);
  logic signed [OW-1:0] re_d, im_d;

  always_comb begin
    re_d = OW'(p_rr) - OW'(p_ii);
    im_d = OW'(p_ri) + OW'(p_ir);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      re_q    <= '0;
      im_q    <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        re_q <= re_d;
        im_q <= im_d;
      end
    end
  end
endmodule

// File: rtl/cmul_fp.sv
module cmul_fp #(
  parameter int unsigned DATA_W = cmul_pkg::CMUL_DATA_W,
  localparam int unsigned OUT_W = DATA_W + 1,
  localparam int unsigned NP    = cmul_pkg::CMUL_NPROD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_in,
  input  logic                     rnd_mode,
  input  logic signed [DATA_W-1:0] a_re,
  input  logic signed [DATA_W-1:0] a_im,
  input  logic signed [DATA_W-1:0] b_re,
  input  logic signed [DATA_W-1:0] b_im,
  output logic                     valid_out,
  output logic signed [OUT_W-1:0]  re_out,
  output logic signed [OUT_W-1:0]  im_out
);
  import cmul_pkg::*;

  // Product order: 0 = a_re*b_re, 1 = a_im*b_im, 2 = a_re*b_im, 3 = a_im*b_re
  logic signed [DATA_W-1:0] op_x [NP];
  logic signed [DATA_W-1:0] op_y [NP];
  logic signed [DATA_W-1:0] cut_d [NP];
  logic signed [DATA_W-1:0] cut_q [NP];
  logic        [NP-1:0]     sat_flags;
  logic                     stage1_valid;
  cut_mode_e                mode_in;

  assign mode_in = cut_mode_e'(rnd_mode);

  always_comb begin
    op_x[0] = a_re;  op_y[0] = b_re;
    op_x[1] = a_im;  op_y[1] = b_im;
    op_x[2] = a_re;  op_y[2] = b_im;
    op_x[3] = a_im;  op_y[3] = b_re;
  end

  for (genvar g = 0; g < NP; g++) begin : g_prod
    cmul_prod_reduce #(.W(DATA_W)) u_red (
      .x        (op_x[g]),
      .y        (op_y[g]),
      .round_en (mode_in == CUT_ROUND),
      .q        (cut_d[g]),
      .sat      (sat_flags[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cut_q[g] <= '0;
      else if (valid_in) cut_q[g] <= cut_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage1_valid <= 1'b0;
    else        stage1_valid <= valid_in;
  end

  cmul_combine #(.W(DATA_W)) u_comb (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (stage1_valid),
    .p_rr    (cut_q[0]),
    .p_ii    (cut_q[1]),
    .p_ri    (cut_q[2]),
    .p_ir    (cut_q[3]),
    .valid_q (valid_out),
    .re_q    (re_out),
    .im_q    (im_out)
  );
endmodule

// File: rtl/cmul_fp_chk.sv
module cmul_fp_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned OUT_W = DATA_W + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     valid_in,
  input logic signed [DATA_W-1:0] a_re,
  input logic signed [DATA_W-1:0] a_im,
  input logic signed [DATA_W-1:0] b_re,
  input logic signed [DATA_W-1:0] b_im,
  input logic                     valid_out,
  input logic signed [OUT_W-1:0]  re_out,
  input logic signed [OUT_W-1:0]  im_out,
  input logic                     stage1_valid
);
  localparam logic signed [DATA_W-1:0] NEG_ONE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [OUT_W-1:0]  IM_MAX  = OUT_W'((1 << DATA_W) - 2);
  localparam logic signed [OUT_W-1:0]  RE_BAD  = {1'b1, {(OUT_W-1){1'b0}}};

  logic all_neg_one;
  assign all_neg_one = (a_re == NEG_ONE) && (a_im == NEG_ONE) &&
                       (b_re == NEG_ONE) && (b_im == NEG_ONE);

  assert_valid_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |-> ##2 valid_out);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |-> ##2 !valid_out);

  assert_re_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (re_out != RE_BAD));

  assert_im_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (im_out <= IM_MAX));

  assert_sat_corner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && all_neg_one) |-> ##2 (re_out == '0 && im_out == IM_MAX));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stage1_valid |=> ($stable(re_out) && $stable(im_out)));
endmodule

bind cmul_fp cmul_fp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .valid_in     (valid_in),
  .a_re         (a_re),
  .a_im         (a_im),
  .b_re         (b_re),
  .b_im         (b_im),
  .valid_out    (valid_out),
  .re_out       (re_out),
  .im_out       (im_out),
  .stage1_valid (stage1_valid)
);

// File: tb/cmul_fp_test.sv
`timescale 1ns/1ps
module cmul_fp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_in = 1'b0;
  logic rnd_mode = 1'b0;
  logic signed [7:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic valid_out;
  logic signed [8:0] re_out, im_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  typedef struct {
    int    re;
    int    im;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  cmul_fp uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .rnd_mode(rnd_mode),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .valid_out(valid_out), .re_out(re_out), .im_out(im_out)
  );

  // Reference cut: exact integer product, optional +64, floor division by 128
  function automatic int ref_cut(int x, int y, bit rnd);
    int t, r, q;
    t = x * y + (rnd ? 64 : 0);
    r = t % 128;
    if (r < 0) r += 128;
    q = (t - r) / 128;
    if (q > 127) q = 127;
    return q;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(int ar, int ai, int br, int bi, bit rnd, string tag);
    exp_t e;
    @(negedge clk);
    valid_in = 1'b1;
    rnd_mode = rnd;
    a_re = 8'(ar); a_im = 8'(ai); b_re = 8'(br); b_im = 8'(bi);
    e.re  = ref_cut(ar, br, rnd) - ref_cut(ai, bi, rnd);
    e.im  = ref_cut(ar, bi, rnd) + ref_cut(ai, br, rnd);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in = 1'b0;
      rnd_mode = ~rnd_mode;
      a_re = 8'($urandom); a_im = 8'($urandom);
      b_re = 8'($urandom); b_im = 8'($urandom);
    end
  endtask

  // Monitor: valid timing, scoreboard compare, hold between results
  bit prev_vin = 1'b0;
  int last_re = 0, last_im = 0;
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      check("R1 valid_out timing", int'(valid_out), int'(prev_vin));
      if (valid_out) begin
        if (sb.size() == 0) begin
          check("R1 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({"R3 re ", e.tag}, int'(re_out), e.re);
          check({"R4 im ", e.tag}, int'(im_out), e.im);
        end
        last_re = int'(re_out);
        last_im = int'(im_out);
      end else begin
        check("R9 re hold", int'(re_out), last_re);
        check("R9 im hold", int'(im_out), last_im);
      end
    end
    prev_vin = valid_in;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R2 valid_out in reset", int'(valid_out), 0);
    check("R2 re_out in reset", int'(re_out), 0);
    check("R2 im_out in reset", int'(im_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R2 valid_out after reset", int'(valid_out), 0);
    check("R2 re_out after reset", int'(re_out), 0);
    mon_on = 1'b1;

    // R3 R4: exact combination, simple values
    send(64, 0, 64, 0, 1'b0, "half*half");
    send(0, 64, 0, 64, 1'b0, "j*j");
    send(64, 32, -32, 64, 1'b1, "mixed");
    idle(3);

    // R5: truncation; 1*64 -> 0, -1*64 -> -1
    send(1, 0, 64, 0, 1'b0, "R5 trunc pos half");
    send(-1, 0, 64, 0, 1'b0, "R5 trunc neg half");
    send(3, 5, 100, -90, 1'b0, "R5 trunc misc");
    // R6: rounding; 1*64 -> 1, -1*64 -> 0
    send(1, 0, 64, 0, 1'b1, "R6 round pos half");
    send(-1, 0, 64, 0, 1'b1, "R6 round neg half");
    send(1, 0, 63, 0, 1'b1, "R6 round below half");
    send(-1, 0, 65, 0, 1'b1, "R6 round neg above half");
    idle(2);

    // R7: saturating corner in both modes
    send(-128, -128, -128, -128, 1'b0, "R7 sat trunc");
    send(-128, -128, -128, -128, 1'b1, "R7 sat round");
    send(-128, 127, -128, 127, 1'b1, "R7 sat mixed");
    send(127, -128, 127, -128, 1'b0, "R7 extremes");
    idle(2);

    // R8: per-item mode with alternating back-to-back sets
    for (int i = 0; i < 8; i++)
      send(1, -1, 64, 64, i[0], "R8 alternating");
    idle(3);

    // Random stream with gaps
    for (int i = 0; i < 3000; i++) begin
      send($signed(8'($urandom)), $signed(8'($urandom)),
           $signed(8'($urandom)), $signed(8'($urandom)),
           1'($urandom), "random");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);

    check("R1 scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule